// File: doc/BRIEF.md
# Four-Wire Byte Control Port (Slave Side)

This block is the slave end of a four-wire serial control link. A host drives a serial clock, an active-low select and a data line into the block. The block answers on an open-drain data line. Each transfer is full duplex and moves one byte in each direction, most significant bit first. While the host shifts a command byte in, the block shifts out a byte that the core has placed on a parallel input. When the select is released, the received byte goes to the core together with a one-cycle valid pulse.

All serial lines are brought into the system clock domain through a synchronizer chain with a parameter for its length, followed by edge detection. The serial clock must be no faster than one eighth of the system clock.

The block also handles transfers that are not eight clocks long:
- A short transfer is delivered right-aligned, with zeros above the received bits.
- A long transfer keeps only the last eight bits received.
- Once the transmit byte has run out, the output line repeats the bits received on the input, starting with the first one.

Top module: `quad_wire_byte_slave`

## Requirements
- R1: While reset is asserted and right after it, `sdo_pull_low_o` is 0, `rx_valid_o` is 0 and `rx_byte_o` is 0.
- R2: While the select input is high, the output is released: `sdo_pull_low_o` is 0, no matter what the serial clock does.
- R3: The transmit byte is captured from `tx_byte_i` when the select falls. Its MSB is placed on the line before the first clock edge. A later change of `tx_byte_i` has no effect on that transfer.
- R4: Input bits are sampled on rising serial clock edges, MSB first. When the select rises, the assembled byte appears on `rx_byte_o` together with a one-cycle `rx_valid_o` pulse.
- R5: The output advances by one bit on each falling serial clock edge while selected. Line encoding: `sdo_pull_low_o`=1 means the line carries 0, and `sdo_pull_low_o`=0 means it carries 1 (released).
- R6: A transfer of n<8 clocks delivers the n received bits in the low n bit positions, with zeros above them.
- R7: A transfer of more than 8 clocks delivers only the last 8 bits received.
- R8: Output slot k (where slot 0 is set up by the select fall and slot k by the k-th falling edge) carries bit 7-k of the transmit byte for k<8. For k≥8 it carries received bit k-8.
- R9: A select low/high cycle with no serial clock edge gives no valid pulse and leaves `rx_byte_o` unchanged.
- R10: `rx_byte_o` changes only in a cycle where `rx_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| sel_n_i | input | 1 | Active-low select from the host |
| sdi_i | input | 1 | Serial data from the host |
| tx_byte_i | input | BYTE_W | Byte the core offers for the next transfer |
| rx_byte_o | output | BYTE_W | Last delivered received byte |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_byte_o` is updated |
| sdo_pull_low_o | output | 1 | Open-drain enable: 1 pulls the output line low |

## Verification
The assertions check the following on every cycle:
- the valid output is always a single-cycle pulse;
- the delivered byte holds between pulses;
- the line is released once the select has been high for longer than the synchronizer latency;
- a delivery happens only while the select is high.

Three behaviours depend on the host's bit sequence and can only be shown by the bench scenarios: right alignment of short transfers, truncation of long ones, and the ordering of the echo. The bench compares a behavioural model against the ports on every clock. It also checks the captured line bits of each slot and each delivered byte against values derived from the requirements.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
   // Positions of the serial lines inside the synchronized bus
   localparam int LINE_SCK = 0;
   localparam int LINE_SEL = 1;
   localparam int LINE_SDI = 2;
   localparam int N_LINES  = 3;

   // Idle levels of the lines (sck low, select high, data low)
   localparam logic [N_LINES-1:0] LINE_IDLE = 3'b010;

   typedef struct packed {
      logic rise;
      logic fall;
   } qwb_edge_t;
endpackage

// File: rtl/qwb_sync.sv
module qwb_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("qwb_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
         end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
         end
      end
      assign q_o = chain[STAGES-1];
   end
endmodule

// File: rtl/qwb_edge.sv
module qwb_edge #(
   parameter int               WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [WIDTH-1:0]                     lvl_i,
   output qwb_pkg::qwb_edge_t [WIDTH-1:0]       ev_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      assign ev_o[i].rise =  lvl_i[i] & ~prev_q[i];
      assign ev_o[i].fall = ~lvl_i[i] &  prev_q[i];
   end
endmodule

// File: rtl/qwb_rx_path.sv
module qwb_rx_path #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stb_i,
   input  logic              bit_i,
   input  logic              end_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              valid_o
);
   logic [BYTE_W-1:0] shreg_q;
   logic              seen_q;

   // Shifting left from a cleared register right-aligns short transfers
   // and leaves only the newest BYTE_W bits of long ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         seen_q  <= 1'b0;
      end else if (start_i) begin
         shreg_q <= '0;
         seen_q  <= 1'b0;
      end else if (stb_i) begin
         shreg_q <= {shreg_q[BYTE_W-2:0], bit_i};
         seen_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= end_i & seen_q;
         if (end_i && seen_q) byte_o <= shreg_q;
      end
   end
endmodule

// File: rtl/qwb_tx_path.sv
module qwb_tx_path #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              sample_i,
   input  logic              bit_i,
   input  logic              shift_i,
   input  logic [BYTE_W-1:0] load_i,
   output logic              pull_low_o
);
   logic [BYTE_W-1:0] shreg_q;
   logic              last_rx_q;
   logic              en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q   <= '1;
         last_rx_q <= 1'b0;
         en_q      <= 1'b0;
      end else begin
         if (start_i) begin
            shreg_q   <= load_i;
            last_rx_q <= 1'b0;
            en_q      <= 1'b1;
         end else begin
            if (stop_i) en_q <= 1'b0;
            if (sample_i) last_rx_q <= bit_i;
            // The latest received bit enters at the bottom, so the
            // received stream follows the transmit byte out of the top.
            if (shift_i) shreg_q <= {shreg_q[BYTE_W-2:0], last_rx_q};
         end
      end
   end

   assign pull_low_o = en_q & ~shreg_q[BYTE_W-1];
endmodule

// File: rtl/quad_wire_byte_slave.sv
module quad_wire_byte_slave #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              sel_n_i,
   input  logic              sdi_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   output logic              sdo_pull_low_o
);
   import qwb_pkg::*;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("quad_wire_byte_slave: BYTE_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("quad_wire_byte_slave: SYNC_STAGES must be 0 to 4");
   end

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;
   qwb_edge_t [N_LINES-1:0] ev;

   assign raw_lines[LINE_SCK] = sck_i;
   assign raw_lines[LINE_SEL] = sel_n_i;
   assign raw_lines[LINE_SDI] = sdi_i;

   qwb_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   qwb_edge #(.WIDTH(N_LINES), .RST_VAL(LINE_IDLE)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_lines),
      .ev_o  (ev)
   );

   logic selected;
   logic xfer_start, xfer_end, clk_rise, clk_fall;

   assign selected   = ~sync_lines[LINE_SEL];
   assign xfer_start = ev[LINE_SEL].fall;
   assign xfer_end   = ev[LINE_SEL].rise;
   assign clk_rise   = ev[LINE_SCK].rise & selected;
   assign clk_fall   = ev[LINE_SCK].fall & selected;

   qwb_rx_path #(.BYTE_W(BYTE_W)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (xfer_start),
      .stb_i   (clk_rise),
      .bit_i   (sync_lines[LINE_SDI]),
      .end_i   (xfer_end),
      .byte_o  (rx_byte_o),
      .valid_o (rx_valid_o)
   );

   qwb_tx_path #(.BYTE_W(BYTE_W)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (xfer_start),
      .stop_i     (xfer_end),
      .sample_i   (clk_rise),
      .bit_i      (sync_lines[LINE_SDI]),
      .shift_i    (clk_fall),
      .load_i     (tx_byte_i),
      .pull_low_o (sdo_pull_low_o)
   );
endmodule

// File: rtl/quad_wire_byte_slave_chk.sv
module quad_wire_byte_slave_chk #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n_i,
   input logic [BYTE_W-1:0] rx_byte_o,
   input logic              rx_valid_o,
   input logic              sdo_pull_low_o
);
   localparam int REL_LAT = SYNC_STAGES + 1;

   int unsigned high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     high_cnt <= 0;
      else if (!sel_n_i)              high_cnt <= 0;
      else if (high_cnt < REL_LAT + 1) high_cnt <= high_cnt + 1;
   end

   // R2: once the select has been high past the synchronizer latency, the line is free
   p_released_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (high_cnt >= REL_LAT) |-> !sdo_pull_low_o);

   // R4: the valid output is a single-cycle pulse
   p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R4: a delivery happens only with the select released
   p_valid_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> sel_n_i);

   // R10: the delivered byte holds between pulses
   p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_o |-> $stable(rx_byte_o));
endmodule

bind quad_wire_byte_slave quad_wire_byte_slave_chk #(
   .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sel_n_i        (sel_n_i),
   .rx_byte_o      (rx_byte_o),
   .rx_valid_o     (rx_valid_o),
   .sdo_pull_low_o (sdo_pull_low_o)
);

// File: tb/test_quad_wire_byte_slave.sv
module test_quad_wire_byte_slave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       sel_n = 1'b1;
   logic       sdi = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic       pull_low;

   int checks = 0;
   int errors = 0;
   int valid_cnt = 0;
   int cycles = 0;
   string cur_tag = "R1";

   always #2 clk = ~clk;

   quad_wire_byte_slave i_quad_wire_byte_slave (
      .clk            (clk),
      .rst_n          (rst_n),
      .sck_i          (sck),
      .sel_n_i        (sel_n),
      .sdi_i          (sdi),
      .tx_byte_i      (tx_byte),
      .rx_byte_o      (rx_byte),
      .rx_valid_o     (rx_valid),
      .sdo_pull_low_o (pull_low)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic d1_sck = 0, d2_sck = 0, p_sck = 0;
   logic d1_sel = 1, d2_sel = 1, p_sel = 1;
   logic d1_sdi = 0, d2_sdi = 0;
   bit   q_rx[$];
   logic [7:0] m_tx = 0, m_byte = 0;
   int   m_rises = 0, m_falls = 0;
   bit   m_en = 0, m_valid = 0, m_drive = 0;

   function automatic bit m_outbit();
      if (m_falls < 8) return m_tx[7-m_falls];
      if (m_falls - 8 < q_rx.size()) return q_rx[m_falls-8];
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         d1_sck = 0; d2_sck = 0; p_sck = 0;
         d1_sel = 1; d2_sel = 1; p_sel = 1;
         d1_sdi = 0; d2_sdi = 0;
         m_en = 0; m_valid = 0; m_drive = 0; m_byte = 0;
      end else begin
         logic v_sck, v_sel, v_sdi;
         v_sck = d2_sck; v_sel = d2_sel; v_sdi = d2_sdi;
         m_valid = 0;
         if (p_sel && !v_sel) begin
            m_tx = tx_byte; q_rx.delete(); m_rises = 0; m_falls = 0; m_en = 1;
         end else if (!p_sel && v_sel) begin
            m_en = 0;
            if (m_rises > 0) begin
               logic [7:0] b;
               b = 0;
               foreach (q_rx[i]) b = {b[6:0], q_rx[i]};
               m_byte = b;
               m_valid = 1;
            end
         end else if (!v_sel) begin
            if (!p_sck && v_sck) begin q_rx.push_back(v_sdi); m_rises++; end
            if (p_sck && !v_sck) m_falls++;
         end
         m_drive = m_en && !m_outbit();
         p_sck = v_sck; p_sel = v_sel;
         d2_sck = d1_sck; d2_sel = d1_sel; d2_sdi = d1_sdi;
         d1_sck = sck; d1_sel = sel_n; d1_sdi = sdi;
      end
   end

   always @(negedge clk) begin
      if (rx_valid) valid_cnt++;
      if (rst_n) begin
         check(pull_low === m_drive, {cur_tag, " line vs model"}, pull_low, m_drive);
         check(rx_valid === m_valid, {cur_tag, " valid vs model"}, rx_valid, m_valid);
         check(rx_byte === m_byte, {cur_tag, " byte vs model"}, rx_byte, m_byte);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs one transfer; returns the line bit seen in each slot
   task automatic xfer(input logic [7:0] txb, input bit bits[$], output bit obs[$]);
      obs.delete();
      tx_byte = txb;
      wait_n(1);
      sel_n = 1'b0;
      wait_n(8);
      obs.push_back(!pull_low);
      foreach (bits[i]) begin
         sdi = bits[i];
         wait_n(4);
         sck = 1'b1;
         wait_n(8);
         sck = 1'b0;
         wait_n(6);
         obs.push_back(!pull_low);
         wait_n(2);
      end
      sel_n = 1'b1;
      wait_n(12);
   endtask

   function automatic logic [7:0] exp_byte(input bit bits[$]);
      logic [7:0] b = 0;
      int first = (bits.size() > 8) ? bits.size() - 8 : 0;
      for (int i = first; i < bits.size(); i++) b = {b[6:0], bits[i]};
      return b;
   endfunction

   task automatic check_slots(input string tag, input logic [7:0] txb, input bit bits[$], input bit obs[$]);
      for (int k = 0; k < obs.size(); k++) begin
         bit e = (k < 8) ? txb[7-k] : bits[k-8];
         check(obs[k] == e, $sformatf("%s slot %0d", tag, k), obs[k], e);
      end
   endtask

   task automatic run_case(input string tag, input logic [7:0] txb, input bit bits[$]);
      bit obs[$];
      int v0 = valid_cnt;
      cur_tag = tag;
      xfer(txb, bits, obs);
      check(rx_byte == exp_byte(bits), {tag, " delivered byte"}, rx_byte, exp_byte(bits));
      check(valid_cnt - v0 == 1, {tag, " one valid pulse"}, valid_cnt - v0, 1);
      check_slots(tag, txb, bits, obs);
   endtask

   initial begin : watchdog
      wait (cycles > 100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      bit obs[$];
      bit bits[$];
      int v0;

      wait_n(4);
      cur_tag = "R1";
      check(pull_low === 1'b0, "R1 line released in reset", pull_low, 0);
      check(rx_valid === 1'b0, "R1 valid low in reset", rx_valid, 0);
      check(rx_byte === 8'h00, "R1 byte zero in reset", rx_byte, 0);
      rst_n = 1'b1;
      wait_n(6);
      check(pull_low === 1'b0 && rx_byte === 8'h00, "R1 state after reset", {pull_low, rx_byte}, 0);

      // R4 R5 R8: full byte, MSB first both ways
      bits = '{0,0,1,1,1,1,0,0};
      run_case("R4", 8'hA5, bits);
      bits = '{1,0,0,0,0,0,0,1};
      run_case("R5", 8'h5A, bits);

      // R3: the transmit byte is frozen at the select fall
      cur_tag = "R3";
      tx_byte = 8'h3C;
      wait_n(1);
      sel_n = 1'b0;
      wait_n(3);
      tx_byte = 8'hC3;
      wait_n(5);
      check(pull_low == 1'b1, "R3 MSB of captured byte before first clock", pull_low, 1);
      v0 = valid_cnt;
      for (int i = 0; i < 8; i++) begin
         sdi = i[0];
         wait_n(4); sck = 1'b1; wait_n(8); sck = 1'b0; wait_n(6);
         check(!pull_low == ((8'h3C >> (6 - i)) & 1) || i == 7,
               $sformatf("R3 slot %0d from captured byte", i + 1), !pull_low, (8'h3C >> (6 - i)) & 1);
         wait_n(2);
      end
      sel_n = 1'b1;
      wait_n(12);
      check(rx_byte == 8'h55, "R3 received byte", rx_byte, 8'h55);

      // R6: short transfer, right aligned
      bits = '{1,0,1};
      run_case("R6", 8'hF0, bits);
      bits = '{1};
      run_case("R6", 8'h0F, bits);

      // R7 R8: long transfer keeps the last eight, echo follows transmit byte
      bits = '{1,1,0,1,0,0,1,0,1,1,1,0,1};
      run_case("R7", 8'h81, bits);
      bits = '{0,1,1,0,1,0,0,1,1,0,0,0,1,1,1,1,0,1};
      run_case("R8", 8'hFF, bits);

      // R9: select pulse without clocks delivers nothing
      cur_tag = "R9";
      v0 = valid_cnt;
      bits.delete();
      xfer(8'h00, bits, obs);
      check(valid_cnt == v0, "R9 no valid without clocks", valid_cnt - v0, 0);
      check(rx_byte == exp_byte('{0,1,1,0,1,0,0,1,1,0,0,0,1,1,1,1,0,1}),
            "R9 byte unchanged", rx_byte, 8'h3D);

      // R2 R10: clock toggling while deselected changes nothing
      cur_tag = "R2";
      v0 = valid_cnt;
      for (int i = 0; i < 6; i++) begin
         sdi = ~sdi;
         wait_n(4); sck = 1'b1; wait_n(8); sck = 1'b0; wait_n(4);
         check(pull_low == 1'b0, "R2 line released while deselected", pull_low, 0);
      end
      wait_n(10);
      check(valid_cnt == v0, "R10 no delivery while deselected", valid_cnt - v0, 0);
      check(rx_byte == 8'h3D, "R10 byte held", rx_byte, 8'h3D);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule